// File: doc/BRIEF.md
# Comparison-Frequency Divider with Lock Detection

This block sits in the reference path of a frequency synthesizer. It divides the crystal reference clock down to the phase-comparison rate and issues one comparison strobe per comparison period. The division ratio comes from a 4-bit code that indexes a fixed set of sixteen ratios. Eight of the ratios are powers of two. The other eight are built on 3 and 5 rather than on 2. A second output gives a square comparison waveform when the ratio is even and a single-cycle pulse when it is odd.

A lock detector watches a one-cycle feedback pulse from the feedback divider. Each comparison period is judged in lock when exactly one feedback pulse falls close to a comparison strobe. "Close" means within a programmable window, counted in reference cycles, on either side of the strobe. The lock flag rises once 64 consecutive periods have been judged in lock. Any bad period drops the flag and starts the run again from zero. A change of the ratio code also restarts the divider and clears the lock state.

Top module: `refdiv_lockdet`

## Requirements
- R1: Codes 0..7 on `ratio_sel` divide by 2, 4, 8, 16, 32, 64, 128, 256 (code k gives 2^(k+1)).
- R2: Codes 8..15 on `ratio_sel` divide by 3, 5, 10, 20, 40, 80, 160, 320 respectively.
- R3: While `rst_n` is low, `locked` is 0, `cmp_strobe` and `cmp_out` are 1, and the stored code is 0. If `ratio_sel` is 0 at release, division by 2 follows at once with no restart.
- R4: `cmp_strobe` is high for exactly one cycle out of every N reference cycles, where N is the selected ratio.
- R5: For an even N, `cmp_out` is high in the strobe cycle and the N/2-1 cycles after it, and low for the other N/2 cycles. For an odd N, `cmp_out` is high only in the strobe cycle.
- R6: Each period runs from a strobe cycle (offset 0) to offset N-1. A period is in lock when exactly one `fb_pulse` occurs at offset d, and either d <= `lock_win` or N-d <= `lock_win`.
- R7: `locked` rises in the cycle after the last cycle of the 64th consecutive in-lock period, and it stays high while periods remain in lock.
- R8: A period that is out of lock (no feedback pulse, two or more pulses, or a pulse outside the window) clears `locked` and restarts the consecutive-period count from zero.
- R9: A `ratio_sel` value that differs from the stored code causes, in the next cycle, `cmp_strobe` high and `locked` low. The new ratio applies from that strobe, and the run count restarts.
- R10: With `lock_win` = 0, only a feedback pulse in the strobe cycle itself counts as in lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal reference clock |
| rst_n | input | 1 | Active-low chip-wide reset |
| ratio_sel | input | 4 | Division ratio code |
| lock_win | input | WIN_W (4) | Lock window in reference cycles |
| fb_pulse | input | 1 | One-cycle feedback divider edge |
| cmp_strobe | output | 1 | One-cycle comparison strobe per period |
| cmp_out | output | 1 | Comparison waveform (square for even ratios, pulse for odd) |
| locked | output | 1 | Lock flag |

## Verification
The divider is tried with every one of the sixteen codes. Measuring both the period and the high time separates the power-of-two ratios from the 3/5-based ones, and shows which waveform shape is produced for odd and even ratios. The lock detector is driven with feedback pulses in several positions: lagging inside the window, leading inside the window, outside it, missing, doubled, and exactly on the strobe with a zero window. The lock outcome for each case confirms both sides of the window test and the 63-versus-64 period threshold. A code change while locked, and a reset while locked, show that the restart clears the flag and realigns the strobe.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
    localparam int CODE_W  = 4;
    localparam int RATIO_W = 9;

    typedef struct packed {
        logic [CODE_W-1:0]  sel;
        logic [RATIO_W-1:0] cnt;
    } div_state_t;

    typedef struct packed {
        logic seen;
        logic good;
    } judge_state_t;

    // Ratio lookup: low half powers of two, high half built on 3 and 5.
    function automatic logic [RATIO_W-1:0] code_to_ratio(input logic [CODE_W-1:0] c);
        logic [RATIO_W-1:0] r;
        if (!c[CODE_W-1])
            r = RATIO_W'(2) << c[CODE_W-2:0];
        else if (c[CODE_W-2:0] == '0)
            r = RATIO_W'(3);
        else
            r = RATIO_W'(5) << (c[CODE_W-2:0] - (CODE_W-1)'(1));
        return r;
    endfunction
endpackage

// File: rtl/refdiv_counter.sv
module refdiv_counter
    import refdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CODE_W-1:0]  ratio_sel,
    output logic [RATIO_W-1:0] cnt,
    output logic [RATIO_W-1:0] ratio,
    output logic               restart,
    output logic               strobe,
    output logic               cmp_out
);
    div_state_t st_q, st_d;

    always_comb begin
        ratio   = code_to_ratio(st_q.sel);
        restart = (ratio_sel != st_q.sel);
        cnt     = st_q.cnt;
        strobe  = (st_q.cnt == '0);
        if (ratio[0])
            cmp_out = strobe;
        else
            cmp_out = (st_q.cnt < (ratio >> 1));

        st_d     = st_q;
        st_d.sel = ratio_sel;
        if (restart)
            st_d.cnt = '0;
        else if (st_q.cnt == ratio - RATIO_W'(1))
            st_d.cnt = '0;
        else
            st_d.cnt = st_q.cnt + RATIO_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < ratio);
    assert_strobe_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !restart) |=> !strobe);
    assert_restart_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> strobe);
endmodule

// File: rtl/refdiv_phase_judge.sv
module refdiv_phase_judge
    import refdiv_pkg::*;
#(
    parameter int WIN_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] cnt,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               restart,
    input  logic [WIN_W-1:0]   win,
    input  logic               fb_pulse,
    output logic               judge_valid,
    output logic               in_lock
);
    localparam int CMP_W = ((RATIO_W > WIN_W) ? RATIO_W : WIN_W) + 1;

    judge_state_t st_q, st_d;
    logic first, near, prev_seen, prev_good, seen_n, good_n;

    always_comb begin
        first     = (cnt == '0);
        near      = (CMP_W'(cnt) <= CMP_W'(win)) ||
                    (CMP_W'(ratio - cnt) <= CMP_W'(win));
        prev_seen = first ? 1'b0 : st_q.seen;
        prev_good = first ? 1'b0 : st_q.good;
        seen_n    = prev_seen | fb_pulse;
        good_n    = fb_pulse ? (!prev_seen && near) : prev_good;

        judge_valid = (cnt == ratio - RATIO_W'(1)) && !restart;
        in_lock     = seen_n && good_n;

        st_d = st_q;
        if (restart) begin
            st_d.seen = 1'b0;
            st_d.good = 1'b0;
        end else begin
            st_d.seen = seen_n;
            st_d.good = good_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assert_judge_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        judge_valid |=> !judge_valid);
endmodule

// File: rtl/refdiv_lock_run.sv
module refdiv_lock_run #(
    parameter int LOCK_RUN = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic judge_valid,
    input  logic in_lock,
    input  logic restart,
    output logic locked
);
    localparam int RUN_W = $clog2(LOCK_RUN + 1);

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic             lck;
    } run_state_t;

    run_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.run = '0;
            st_d.lck = 1'b0;
        end else if (judge_valid) begin
            if (in_lock) begin
                if (st_q.run != RUN_W'(LOCK_RUN))
                    st_d.run = st_q.run + RUN_W'(1);
                st_d.lck = (st_d.run == RUN_W'(LOCK_RUN));
            end else begin
                st_d.run = '0;
                st_d.lck = 1'b0;
            end
        end
        locked = st_q.lck;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assert_lock_needs_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lck |-> (st_q.run == RUN_W'(LOCK_RUN)));
    assert_unlock_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !locked);
    assert_clear_on_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (judge_valid && !in_lock && !restart) |=> (!locked && st_q.run == '0));
endmodule

// File: rtl/refdiv_lockdet.sv
module refdiv_lockdet
    import refdiv_pkg::*;
#(
    parameter int WIN_W    = 4,
    parameter int LOCK_RUN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        ratio_sel,
    input  logic [WIN_W-1:0]  lock_win,
    input  logic              fb_pulse,
    output logic              cmp_strobe,
    output logic              cmp_out,
    output logic              locked
);
    logic [RATIO_W-1:0] cnt, ratio;
    logic restart, judge_valid, in_lock;

    refdiv_counter u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .ratio_sel (ratio_sel),
        .cnt       (cnt),
        .ratio     (ratio),
        .restart   (restart),
        .strobe    (cmp_strobe),
        .cmp_out   (cmp_out)
    );

    refdiv_phase_judge #(.WIN_W(WIN_W)) u_judge (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt         (cnt),
        .ratio       (ratio),
        .restart     (restart),
        .win         (lock_win),
        .fb_pulse    (fb_pulse),
        .judge_valid (judge_valid),
        .in_lock     (in_lock)
    );

    refdiv_lock_run #(.LOCK_RUN(LOCK_RUN)) u_run (
        .clk         (clk),
        .rst_n       (rst_n),
        .judge_valid (judge_valid),
        .in_lock     (in_lock),
        .restart     (restart),
        .locked      (locked)
    );

    assert_rise_after_judge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !(judge_valid && in_lock)) |=> !locked);
endmodule

// File: tb/sim_refdiv_lockdet.sv
module sim_refdiv_lockdet;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ratio_sel = 4'd0;
    logic [3:0] lock_win = 4'd1;
    logic       fb_pulse = 1'b0;
    logic       cmp_strobe, cmp_out, locked;

    int n_checks = 0;
    int n_fail   = 0;
    int cur_n    = 2;
    bit done     = 1'b0;

    localparam int RATIO_TAB [16] = '{2, 4, 8, 16, 32, 64, 128, 256,
                                      3, 5, 10, 20, 40, 80, 160, 320};

    always #4 clk = ~clk;

    refdiv_lockdet u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ratio_sel  (ratio_sel),
        .lock_win   (lock_win),
        .fb_pulse   (fb_pulse),
        .cmp_strobe (cmp_strobe),
        .cmp_out    (cmp_out),
        .locked     (locked)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Runs whole comparison periods starting at the next strobe, with feedback
    // pulses at offsets k1 and k2 (negative means none). Ends at the negedge
    // of the strobe cycle that follows the last period.
    task automatic run_periods(input int count, input int k1, input int k2);
        fb_pulse = 1'b0;
        while (!cmp_strobe) @(negedge clk);
        for (int p = 0; p < count; p++) begin
            for (int off = 0; off < cur_n; off++) begin
                fb_pulse = (off == k1) || (off == k2);
                @(negedge clk);
            end
        end
        fb_pulse = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R3 locked in reset", int'(locked), 0);
        chk("R3 strobe in reset", int'(cmp_strobe), 1);
        chk("R3 cmp_out in reset", int'(cmp_out), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 divide-by-2 without restart", int'(cmp_strobe), 0);
        @(negedge clk);
        chk("R3 second strobe after 2 cycles", int'(cmp_strobe), 1);

        // Ratio table walk: R1, R2, R4, R5
        for (int c = 0; c < 16; c++) begin
            int n;
            int hi;
            int strobes;
            int exp_hi;
            ratio_sel = 4'(c);
            @(negedge clk);
            while (!cmp_strobe) @(negedge clk);
            n = 0; hi = 0; strobes = 0;
            do begin
                if (cmp_out) hi++;
                if (cmp_strobe) strobes++;
                n++;
                @(negedge clk);
            end while (!cmp_strobe);
            exp_hi = (RATIO_TAB[c] % 2 == 0) ? RATIO_TAB[c] / 2 : 1;
            chk(c < 8 ? "R1 period" : "R2 period", n, RATIO_TAB[c]);
            chk("R5 high time", hi, exp_hi);
            chk("R4 one strobe per period", strobes, 1);
        end

        // Lock detection with N = 8, window 1
        ratio_sel = 4'd2; cur_n = 8; lock_win = 4'd1;
        @(negedge clk);
        chk("R9 unlocked after code change", int'(locked), 0);
        run_periods(63, 1, -1);
        chk("R7 not locked after 63", int'(locked), 0);
        run_periods(1, 1, -1);
        chk("R7 locked after 64", int'(locked), 1);
        run_periods(1, 7, -1);
        chk("R6 leading pulse inside window", int'(locked), 1);
        run_periods(1, 4, -1);
        chk("R8 far pulse clears lock", int'(locked), 0);
        run_periods(63, 7, -1);
        chk("R8 count restarted (63)", int'(locked), 0);
        run_periods(1, 0, -1);
        chk("R8 relock after 64 more", int'(locked), 1);
        run_periods(1, -1, -1);
        chk("R8 missing pulse clears lock", int'(locked), 0);
        run_periods(64, 1, -1);
        chk("R7 relock", int'(locked), 1);
        run_periods(1, 1, 2);
        chk("R8 double pulse clears lock", int'(locked), 0);
        run_periods(64, 2, -1);
        chk("R6 offset 2 outside window 1", int'(locked), 0);

        // Code change while locked
        run_periods(64, 1, -1);
        chk("R7 locked before change", int'(locked), 1);
        ratio_sel = 4'd3; cur_n = 16;
        @(negedge clk);
        chk("R9 lock cleared on change", int'(locked), 0);
        chk("R9 strobe restarts at once", int'(cmp_strobe), 1);
        begin
            int n;
            n = 0;
            do begin n++; @(negedge clk); end while (!cmp_strobe);
            chk("R9 new ratio applies", n, 16);
        end

        // Zero window
        lock_win = 4'd0;
        run_periods(64, 0, -1);
        chk("R10 on-strobe pulse locks", int'(locked), 1);
        run_periods(1, 15, -1);
        chk("R10 one-cycle lead rejected", int'(locked), 0);

        // Reset while locked
        run_periods(64, 0, -1);
        chk("R7 locked before reset", int'(locked), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R3 reset clears lock", int'(locked), 0);
        chk("R3 reset strobe", int'(cmp_strobe), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule